// File: doc/BRIEF.md
# Edge-Selectable Capture Interrupt Input

This block lets an asynchronous external pin raise an interrupt request by way of an auxiliary timer channel running in capture mode. The pin is brought into the clock domain through a chain of flip-flops. The block then compares consecutive synchronised samples to find low-to-high and high-to-low transitions. A programmable edge-select field chooses which of those transitions count.

On a qualifying transition, the block copies the running core timer value into a capture register. In the same cycle it sets a sticky request flag. The flag stays set until software pulses a clear strobe.

Detection is armed only when two conditions hold: the 3-bit channel mode field holds the capture code, and the pin's port direction bit leaves the pin as an input. The pin keeps its ordinary peripheral role while it serves as an interrupt source. Arbitration, vectoring and transfer servicing of the request belong to other blocks.

Top module: `cap_irq_input`

## Requirements
- R1: Requests are generated only while `mode_i` equals 3'b101; for any other mode value no edge sets the flag or loads the capture register.
- R2: With `esel_i[1:0]` = 2'b01, a low-to-high transition of the synchronised pin is a qualifying edge and a high-to-low transition is not.
- R3: With `esel_i[1:0]` = 2'b10, a high-to-low transition is a qualifying edge and a low-to-high transition is not.
- R4: With `esel_i[1:0]` = 2'b11, both transition directions are qualifying edges, including two transitions on consecutive clocks.
- R5: With `esel_i[1:0]` = 2'b00, no transition is a qualifying edge.
- R6: Bit 2 of `esel_i` has no effect on which edges qualify.
- R7: While `dir_out_i` is 1 (pin driven as an output), no edge sets the flag or loads the capture register; detection needs `dir_out_i` = 0.
- R8: With the default two synchroniser stages, a pin change set up before clock edge k appears on `irq_flag_o` after edge k+2, and never later.
- R9: On every qualifying edge, `capture_o` takes the value of `timer_i` sampled at the same clock edge that sets the flag, also when the flag is already set. Otherwise `capture_o` holds its value.
- R10: `irq_flag_o` stays set until `flag_clr_i` is sampled high. A clear that arrives with no qualifying edge in the same cycle drops the flag. A clear that arrives together with a qualifying edge leaves the flag set.
- R11: Changing `mode_i`, `esel_i` or `dir_out_i` while the pin level is steady never produces a qualifying edge, because edge history keeps tracking the pin while detection is off.
- R12: While `rst_n` is low, `irq_flag_o` is 0 and `capture_o` is 0, and the synchroniser and edge history restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw external pin, asynchronous to `clk` |
| mode_i | input | 3 | Channel mode field; 3'b101 selects capture |
| esel_i | input | 3 | Edge select; bits 1:0 pick none/rise/fall/both, bit 2 ignored |
| dir_out_i | input | 1 | Port direction bit; 1 = output, 0 = input |
| timer_i | input | TIMER_W | Running core timer value |
| flag_clr_i | input | 1 | Software clear strobe for the request flag |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| capture_o | output | TIMER_W | Timer value latched at the last qualifying edge |

## Verification
A synchroniser or history register holding a stale value shows up in one of two ways: the flag rises one clock early or late against the fixed three-edge latency, or a flag appears with no pin movement when detection is armed. A reference model that follows every cycle catches either within the cycle in which the flag should or should not change. A wrong arming decode or edge-select decode shows as a missing flag or an extra flag within three clocks of a pin change. A capture register loading at the wrong edge shows as a `capture_o` value one timer step off on the same cycle the flag rises.

// File: rtl/cap_irq_pkg.sv
package cap_irq_pkg;

    // Mode code that turns the auxiliary channel into a capture input
    localparam logic [2:0] MODE_CAPTURE = 3'b101;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("cap_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[LAST-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[LAST];

endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [2:0] mode_i,
    input  logic [2:0] esel_i,
    input  logic       dir_out_i,
    output logic       hit_o
);
    typedef struct packed {
        logic hist;
    } edge_state_t;

    edge_state_t st_d, st_q;
    edge_evt_t   evt;
    edge_sel_e   sel;
    logic        armed;
    logic        hit_d;

    always_comb begin
        st_d      = st_q;
        // history always follows the pin so re-arming never sees a fake edge
        st_d.hist = sync_i;

        evt.rise = sync_i & ~st_q.hist;
        evt.fall = ~sync_i & st_q.hist;

        armed = (mode_i == MODE_CAPTURE) && !dir_out_i;

        unique casez (esel_i)
            3'b?01:  sel = EDGE_RISE;
            3'b?10:  sel = EDGE_FALL;
            3'b?11:  sel = EDGE_BOTH;
            default: sel = EDGE_NONE;
        endcase

        unique case (sel)
            EDGE_RISE: hit_d = evt.rise;
            EDGE_FALL: hit_d = evt.fall;
            EDGE_BOTH: hit_d = evt.rise | evt.fall;
            default:   hit_d = 1'b0;
        endcase
        hit_d = hit_d & armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = hit_d;

endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         clr_i,
    input  logic [W-1:0] timer_i,
    output logic         flag_o,
    output logic [W-1:0] cap_o
);
    typedef struct packed {
        logic         flag;
        logic [W-1:0] cap;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (hit_i) begin
            // a new edge wins over a simultaneous clear
            st_d.flag = 1'b1;
            st_d.cap  = timer_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign cap_o  = st_q.cap;

endmodule

// File: rtl/cap_irq_input.sv
module cap_irq_input #(
    parameter int TIMER_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [2:0]         mode_i,
    input  logic [2:0]         esel_i,
    input  logic               dir_out_i,
    input  logic [TIMER_W-1:0] timer_i,
    input  logic               flag_clr_i,
    output logic               irq_flag_o,
    output logic [TIMER_W-1:0] capture_o
);
    logic pin_sync;
    logic edge_hit;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    cap_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (pin_sync),
        .mode_i    (mode_i),
        .esel_i    (esel_i),
        .dir_out_i (dir_out_i),
        .hit_o     (edge_hit)
    );

    cap_latch #(.W(TIMER_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (edge_hit),
        .clr_i   (flag_clr_i),
        .timer_i (timer_i),
        .flag_o  (irq_flag_o),
        .cap_o   (capture_o)
    );

endmodule

// File: rtl/cap_irq_chk.sv
module cap_irq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   mode_i,
    input logic [2:0]   esel_i,
    input logic         dir_out_i,
    input logic [W-1:0] timer_i,
    input logic         flag_clr_i,
    input logic         hit,
    input logic         irq_flag_o,
    input logic [W-1:0] capture_o
);
    // R1
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 3'b101) |-> !hit);

    // R7
    dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out_i |=> !$rose(irq_flag_o));

    // R5
    no_edge_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (esel_i[1:0] == 2'b00) |=> !$rose(irq_flag_o));

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !flag_clr_i) |=> irq_flag_o);

    // R10
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !hit) |=> !irq_flag_o);

    // R10
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq_flag_o);

    // R9
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (capture_o == $past(timer_i)));

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(capture_o));

    // R12
    always_comb begin
        if (!rst_n) begin
            reset_state_chk: assert (!irq_flag_o && capture_o == '0);
        end
    end

endmodule

bind cap_irq_input cap_irq_chk #(.W(TIMER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .esel_i     (esel_i),
    .dir_out_i  (dir_out_i),
    .timer_i    (timer_i),
    .flag_clr_i (flag_clr_i),
    .hit        (edge_hit),
    .irq_flag_o (irq_flag_o),
    .capture_o  (capture_o)
);

// File: tb/sim_cap_irq_input.sv
`timescale 1ns/1ps
module sim_cap_irq_input;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin_i = 1'b0;
    logic [2:0]   mode_i = 3'b000;
    logic [2:0]   esel_i = 3'b000;
    logic         dir_out_i = 1'b0;
    logic [W-1:0] timer_i = '0;
    logic         flag_clr_i = 1'b0;
    logic         irq_flag_o;
    logic [W-1:0] capture_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R12 reset";
    bit    done = 1'b0;

    // reference model state
    bit           ph[$];
    bit           m_flag = 1'b0;
    logic [W-1:0] m_cap = '0;

    always #2 clk = ~clk;

    cap_irq_input #(.TIMER_W(W), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .mode_i     (mode_i),
        .esel_i     (esel_i),
        .dir_out_i  (dir_out_i),
        .timer_i    (timer_i),
        .flag_clr_i (flag_clr_i),
        .irq_flag_o (irq_flag_o),
        .capture_o  (capture_o)
    );

    function automatic bit model_hit(bit cur, bit prv);
        bit r;
        bit f;
        r = cur && !prv;
        f = !cur && prv;
        if (mode_i != 3'b101 || dir_out_i) return 1'b0;
        case (esel_i[1:0])
            2'b01:   return r;
            2'b10:   return f;
            2'b11:   return r || f;
            default: return 1'b0;
        endcase
    endfunction

    task automatic cmp_now();
        n_cmp++;
        if (irq_flag_o !== m_flag) begin
            n_bad++;
            $display("FAIL %s flag: actual=%0b expected=%0b t=%0t", phase, irq_flag_o, m_flag, $time);
        end
        n_cmp++;
        if (capture_o !== m_cap) begin
            n_bad++;
            $display("FAIL %s capture: actual=%0h expected=%0h t=%0t", phase, capture_o, m_cap, $time);
        end
    endtask

    // model advances on every edge, then the outputs are compared 1 ns later
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = {1'b0, 1'b0, 1'b0, 1'b0};
            m_flag = 1'b0;
            m_cap = '0;
        end else begin
            bit h;
            ph.push_front(pin_i);
            h = model_hit(ph[2], ph[3]);   // R8: three-edge latency
            if (h) m_cap = timer_i;        // R9
            m_flag = h || (m_flag && !flag_clr_i); // R10
            void'(ph.pop_back());
        end
        #1;
        if (!done) cmp_now();
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            timer_i = timer_i + 16'd7;
        end
    endtask

    task automatic clr();
        flag_clr_i = 1'b1;
        tick(1);
        flag_clr_i = 1'b0;
    endtask

    task automatic toggle_pair();
        pin_i = 1'b1; tick(6);
        pin_i = 1'b0; tick(6);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        bit [7:0] lfsr;
        tick(3);
        // R12: reset state at the ports
        n_cmp++;
        if (irq_flag_o !== 1'b0 || capture_o !== '0) begin
            n_bad++;
            $display("FAIL R12 reset: actual=%0b/%0h expected=0/0", irq_flag_o, capture_o);
        end
        rst_n = 1'b1;
        mode_i = 3'b101;
        tick(3);

        phase = "R2 rising select";
        esel_i = 3'b001;
        pin_i = 1'b1; tick(6); clr(); tick(2);
        pin_i = 1'b0; tick(6); clr();

        phase = "R3 falling select";
        esel_i = 3'b010;
        pin_i = 1'b1; tick(6);
        pin_i = 1'b0; tick(6); clr(); tick(2);

        phase = "R4 both select";
        esel_i = 3'b011;
        pin_i = 1'b1; tick(6); clr(); tick(2);
        pin_i = 1'b0; tick(6); clr(); tick(2);
        pin_i = 1'b1; tick(1); pin_i = 1'b0; tick(6); clr(); tick(2);

        phase = "R6 top select bit";
        esel_i = 3'b101; toggle_pair(); clr();
        esel_i = 3'b110; toggle_pair(); clr();
        esel_i = 3'b111; toggle_pair(); clr();

        phase = "R5 no-edge select";
        esel_i = 3'b000; toggle_pair();
        esel_i = 3'b100; toggle_pair();

        phase = "R1 other modes";
        esel_i = 3'b011;
        mode_i = 3'b100; toggle_pair();
        mode_i = 3'b001; toggle_pair();
        mode_i = 3'b111; toggle_pair();
        mode_i = 3'b000; toggle_pair();
        mode_i = 3'b101;

        phase = "R7 pin as output";
        dir_out_i = 1'b1; toggle_pair();

        phase = "R11 no spurious on re-arm";
        pin_i = 1'b1; tick(6);
        dir_out_i = 1'b0; tick(6);
        mode_i = 3'b010; pin_i = 1'b0; tick(6);
        mode_i = 3'b101; tick(6);
        esel_i = 3'b000; pin_i = 1'b1; tick(6);
        esel_i = 3'b001; tick(4); esel_i = 3'b010; tick(4); esel_i = 3'b011; tick(6);

        phase = "R10 clear meets edge";
        pin_i = 1'b0; tick(6); clr(); tick(2);
        pin_i = 1'b1; tick(2);
        flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
        tick(4);

        phase = "R9 recapture while set";
        pin_i = 1'b0; tick(6);
        pin_i = 1'b1; tick(6);
        clr(); tick(3);

        phase = "R8 latency mixed traffic";
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pin_i = lfsr[0];
            flag_clr_i = (lfsr[3:1] == 3'b000);
            if (i % 50 == 0) esel_i = lfsr[7:5];
            if (i % 70 == 0) mode_i = lfsr[2] ? 3'b101 : lfsr[6:4];
            tick(1);
        end
        flag_clr_i = 1'b0;
        tick(6);
        finish_run();
    end

endmodule